// File: doc/BRIEF.md
# SPI Flash Programmed-Cycle Controller

This block lets software run single SPI flash commands through a small register window. Software loads a 24-bit flash address, and for writes it also fills a 64-byte data buffer. It then writes the control register with an opcode, a data-phase enable, a byte count and the start bit. The controller drops chip select and sends the opcode. It then sends the address most significant bit first and shifts the data bytes out of the buffer or into it, in SPI mode 0, with SCLK at half the system clock rate. Three status flags report the state of the cycle: busy, done and refused. The done flag can drive an interrupt-style request line.

After reset the controller does not wait for software. It repeatedly reads the flash status byte until the device reports it is no longer busy. During that sequence the controller looks like a cycle in progress. A lockable base/limit pair protects a flash address range against program and erase opcodes. The lock is sticky until reset.

Top module: `spi_flash_cycle_ctrl`

## Requirements
- R1: Reset leaves the control register at 16'h4001. After release the controller issues frames made of opcode 8'h05 followed by one input byte, and repeats them while bit 0 of that byte is 1. Throughout this, status bit 0 reads 1 and status bit 1 reads 0. When a frame returns bit 0 = 0, status bit 1 becomes 1 and bit 0 becomes 0.
- R2: A write to the control register (address 33) with byte enable 0 set and data bit 1 set starts a cycle while idle. Chip select falls, the 8-bit opcode from data bits 7:0 is sent, and then the address register (address 34 holds bits 15:0, address 35 bits 7:0 hold bits 23:16) is sent MSB first. SCLK idles low and MOSI is stable around each rising edge.
- R3: When control bit 14 is 1, the cycle carries a data phase of (control bits 13:8) + 1 bytes, from 1 to 64. When bit 14 is 0, the frame ends after the address and the count field has no effect.
- R4: With opcode 8'h02 the data phase sends buffer bytes 0, 1, 2, ... in order. With any other opcode, data byte k is taken from MISO into buffer byte k. Buffer word w (addresses 0..31) holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8.
- R5: Status (address 32) bit 0 reads 1 from the start write until the frame ends. Writes to this bit have no effect.
- R6: Status bit 1 is set when a started cycle ends. Writing 1 to it clears it, and writing 0 leaves it.
- R7: Output smi_req is 1 exactly while control bit 15 and status bit 1 are both 1.
- R8: A write to control, address or buffer registers while status bit 0 is 1 is discarded, and it sets status bit 2.
- R9: Status bit 2 stays set until software writes 1 to it.
- R10: Writing 1 to status bit 15 sets the lock. Only reset clears it. While it is set, the protection base (36: bits 15:0, 37: bits 7:0 as 23:16) and limit (38, 39, laid out the same way) ignore writes.
- R11: While locked, a start with opcode 8'h02 or 8'h52 whose address lies within base..limit inclusive produces no frame. It sets status bit 2 and leaves status bit 1 unchanged.
- R12: Register writes honour byte enables (bit 0 for bits 7:0, bit 1 for bits 15:8). Control bit 1 reads back as 0 after a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 2 | Byte enables for the write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| smi_req | output | 1 | Completion request line |
| sclk | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to flash |
| miso | input | 1 | SPI data from flash |

## Verification
A controller that keeps running after its last byte, or stops early, shows at the pins as a wrong number of captured bytes in the frame. It also shows in status within one register read of the frame ending. A wrong phase pointer turns the address bytes, or buffer bytes read back, into values that do not match. A protection or lock state that has drifted shows on the next start as a frame that should not exist, or one that is missing, together with the refused flag. A lost or stale done flag appears on smi_req in the next cycle.

// File: rtl/spi_flash_cycle_ctrl.sv
module spi_flash_cycle_ctrl #(
  parameter logic [7:0] POLL_OPCODE  = 8'h05,
  parameter logic [7:0] PROG_OPCODE  = 8'h02,
  parameter logic [7:0] ERASE_OPCODE = 8'h52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_we,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        smi_req,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);

  localparam logic [5:0] A_STAT = 6'd32, A_CTL = 6'd33, A_ADL = 6'd34, A_ADH = 6'd35;
  localparam logic [5:0] A_BSL = 6'd36, A_BSH = 6'd37, A_LML = 6'd38, A_LMH = 6'd39;

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADR, S_DAT, S_POLL, S_GAP} state_t;

  state_t      st;
  logic        half, polling, lock, ba, done;
  logic [2:0]  bit_i;
  logic [5:0]  byte_i;
  logic [7:0]  sh, op_q;
  logic [6:0]  rx;
  logic [15:0] ctl;
  logic [23:0] faddr, pbase, plimit;
  logic [7:0]  dbuf [64];

  wire         cip      = (st != S_IDLE);
  wire [15:0]  bemask   = {{8{reg_be[1]}}, {8{reg_be[0]}}};
  wire [15:0]  ctl_new  = (ctl & ~bemask) | (reg_wdata & bemask);
  wire         wr_prog  = reg_we && (!reg_addr[5] || reg_addr == A_CTL || reg_addr == A_ADL || reg_addr == A_ADH);
  wire         go_req   = wr_prog && !cip && reg_addr == A_CTL && reg_be[0] && reg_wdata[1];
  wire         is_mod   = (ctl_new[7:0] == PROG_OPCODE) || (ctl_new[7:0] == ERASE_OPCODE);
  wire         refuse   = go_req && lock && is_mod && faddr >= pbase && faddr <= plimit;
  wire [7:0]   rx_byte  = {rx, miso};
  wire         byte_end = half && bit_i == 3'd7;

  assign cs_n    = (st == S_IDLE) || (st == S_GAP);
  assign sclk    = !cs_n && half;
  assign mosi    = !cs_n && sh[7];
  assign smi_req = ctl[15] && done;

  always_comb begin
    reg_rdata = 16'h0000;
    if (!reg_addr[5])
      reg_rdata = {dbuf[{reg_addr[4:0], 1'b1}], dbuf[{reg_addr[4:0], 1'b0}]};
    else
      case (reg_addr)
        A_STAT:  reg_rdata = {lock, 12'h000, ba, done, cip};
        A_CTL:   reg_rdata = ctl;
        A_ADL:   reg_rdata = faddr[15:0];
        A_ADH:   reg_rdata = {8'h00, faddr[23:16]};
        A_BSL:   reg_rdata = pbase[15:0];
        A_BSH:   reg_rdata = {8'h00, pbase[23:16]};
        A_LML:   reg_rdata = plimit[15:0];
        A_LMH:   reg_rdata = {8'h00, plimit[23:16]};
        default: reg_rdata = 16'h0000;
      endcase
  end

  always_ff @(posedge clk) begin
    if (reg_we && !reg_addr[5] && !cip) begin
      if (reg_be[0]) dbuf[{reg_addr[4:0], 1'b0}] <= reg_wdata[7:0];
      if (reg_be[1]) dbuf[{reg_addr[4:0], 1'b1}] <= reg_wdata[15:8];
    end
    if (st == S_DAT && byte_end && op_q != PROG_OPCODE)
      dbuf[byte_i] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP;  polling <= 1'b1;  half <= 1'b0;  bit_i <= 3'd0;  byte_i <= 6'd0;
      sh <= 8'h00;  rx <= 7'h00;  op_q <= 8'h00;  ctl <= 16'h4001;
      faddr <= '0;  pbase <= '0;  plimit <= '0;  lock <= 1'b0;  ba <= 1'b0;  done <= 1'b0;
    end else begin
      if (reg_we) begin
        if (reg_addr == A_STAT) begin
          if (reg_be[1] && reg_wdata[15]) lock <= 1'b1;
          if (reg_be[0] && reg_wdata[2])  ba   <= 1'b0;
          if (reg_be[0] && reg_wdata[1])  done <= 1'b0;
        end
        if (!lock)
          case (reg_addr)
            A_BSL:   pbase[15:0]   <= (pbase[15:0]  & ~bemask) | (reg_wdata & bemask);
            A_BSH:   if (reg_be[0]) pbase[23:16]  <= reg_wdata[7:0];
            A_LML:   plimit[15:0]  <= (plimit[15:0] & ~bemask) | (reg_wdata & bemask);
            A_LMH:   if (reg_be[0]) plimit[23:16] <= reg_wdata[7:0];
            default: ;
          endcase
        if (wr_prog && cip) ba <= 1'b1;
        else if (wr_prog)
          case (reg_addr)
            A_CTL:   ctl <= ctl_new & ~16'h0002;
            A_ADL:   faddr[15:0] <= (faddr[15:0] & ~bemask) | (reg_wdata & bemask);
            A_ADH:   if (reg_be[0]) faddr[23:16] <= reg_wdata[7:0];
            default: ;
          endcase
      end
      if (refuse) ba <= 1'b1;
      if (go_req && !refuse) begin
        st <= S_OP;  sh <= ctl_new[7:0];  op_q <= ctl_new[7:0];
        half <= 1'b0;  bit_i <= 3'd0;  byte_i <= 6'd0;
      end

      case (st)
        S_OP, S_ADR, S_DAT, S_POLL: begin
          half <= ~half;
          if (half) begin
            rx    <= rx_byte[6:0];
            sh    <= {sh[6:0], 1'b0};
            bit_i <= bit_i + 3'd1;
            if (bit_i == 3'd7)
              case (st)
                S_OP:
                  if (polling) st <= S_POLL;
                  else begin st <= S_ADR; byte_i <= 6'd0; sh <= faddr[23:16]; end
                S_ADR:
                  if (byte_i == 6'd0)      begin byte_i <= 6'd1; sh <= faddr[15:8]; end
                  else if (byte_i == 6'd1) begin byte_i <= 6'd2; sh <= faddr[7:0]; end
                  else if (ctl[14])        begin st <= S_DAT; byte_i <= 6'd0; sh <= dbuf[0]; end
                  else st <= S_GAP;
                S_DAT:
                  if (byte_i == ctl[13:8]) st <= S_GAP;
                  else begin byte_i <= byte_i + 6'd1; sh <= dbuf[byte_i + 6'd1]; end
                default: begin
                  if (!rx_byte[0]) polling <= 1'b0;
                  st <= S_GAP;
                end
              endcase
          end
        end
        S_GAP:
          if (polling) begin
            st <= S_OP;  sh <= POLL_OPCODE;  half <= 1'b0;  bit_i <= 3'd0;
          end else begin
            st <= S_IDLE;  done <= 1'b1;
          end
        default: ;
      endcase
    end
  end

  AST_DONE_HELD_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n) polling |-> !done); // R1
  AST_DONE_AT_END:       assert property (@(posedge clk) disable iff (!rst_n) $fell(cip) |-> done); // R6
  AST_DATA_NEEDS_DC:     assert property (@(posedge clk) disable iff (!rst_n) (st == S_DAT) |-> ctl[14]); // R3
  AST_COUNT_BOUND:       assert property (@(posedge clk) disable iff (!rst_n) (st == S_DAT) |-> byte_i <= ctl[13:8]); // R3
  AST_ADDR_HELD_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (cip && $past(cip)) |-> $stable(faddr)); // R8
  AST_LOCK_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) $past(lock) |-> lock); // R10
  AST_CFG_FROZEN:        assert property (@(posedge clk) disable iff (!rst_n) $past(lock) |-> ($stable(pbase) && $stable(plimit))); // R10
  AST_REFUSED_SILENT:    assert property (@(posedge clk) disable iff (!rst_n) $past(refuse) |-> cs_n); // R11

endmodule

// File: tb/spi_flash_cycle_ctrl_test.sv
`timescale 1ns/1ps
module spi_flash_cycle_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = 6'd0;
  logic [1:0]  reg_be = 2'b11;
  logic [15:0] reg_wdata = 16'h0000;
  logic [15:0] reg_rdata;
  logic        smi_req, sclk, cs_n, mosi, miso;

  int tests = 0, failed = 0;
  int frames = 0, capn = 0, bitn = 0, bitpos = 0, busy_polls = 2;
  logic [7:0] shin = 8'h00;
  logic [7:0] cap [0:79];

  spi_flash_cycle_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_req(smi_req),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  always #2.5 clk = ~clk;

  always @(negedge cs_n) begin frames++; capn = 0; bitn = 0; bitpos = 0; end
  always @(posedge sclk) begin
    shin = {shin[6:0], mosi}; bitn++;
    if (bitn == 8) begin if (capn < 80) cap[capn] = shin; capn++; bitn = 0; end
  end
  always @(negedge sclk) bitpos++;
  always @(posedge cs_n) if (capn >= 1 && cap[0] == 8'h05 && busy_polls > 0) busy_polls--;

  wire [7:0] resp = ((bitpos / 8) == 1) ? ((busy_polls > 0) ? 8'h01 : 8'h00) : 8'(8'hA0 + bitpos / 8);
  assign miso = !cs_n && resp[3'(7 - bitpos % 8)];

  function automatic logic [7:0] pat(int i); return 8'(i * 3 + 1); endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin failed++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d, logic [1:0] be = 2'b11);
    @(negedge clk); reg_addr = a; reg_be = be; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); rd(6'd32, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] s, c;
    @(negedge clk); rd(6'd32, s); rd(6'd33, c);
    check(s == 16'h0001, "R1 status during poll", s, 16'h0001);
    check(c == 16'h4001, "R1 control reset", c, 16'h4001);
    wait_idle();
    rd(6'd32, s);
    check(frames == 3, "R1 poll frame count", frames, 3);
    check(cap[0] == 8'h05 && capn == 2, "R1 poll frame", {cap[0], 8'(capn)}, {8'h05, 8'd2});
    check(s == 16'h0002, "R1 done after poll", s, 16'h0002);
  endtask

  task automatic t_read();
    logic [15:0] s, w0, w1, c;
    int f0;
    wr(6'd32, 16'h0002);
    wr(6'd34, 16'h3456); wr(6'd35, 16'h0012);
    f0 = frames;
    wr(6'd33, 16'h4303);
    rd(6'd32, s);
    check(s == 16'h0001, "R5 busy after start", s, 16'h0001);
    wait_idle();
    check(frames == f0 + 1 && capn == 8, "R3 read frame length", capn, 8);
    check({cap[0], cap[1], cap[2], cap[3]} == 32'h03123456, "R2 opcode and address", {cap[0], cap[1], cap[2], cap[3]}, 32'h03123456);
    rd(6'd0, w0); rd(6'd1, w1);
    check({w1, w0} == 32'hA7A6A5A4, "R4 captured data", {w1, w0}, 32'hA7A6A5A4);
    rd(6'd32, s);
    check(s == 16'h0002, "R6 done set", s, 16'h0002);
    rd(6'd33, c);
    check(c == 16'h4301, "R12 go self clears", c, 16'h4301);
    wr(6'd33, 16'hFF00, 2'b01); rd(6'd33, c);
    check(c == 16'h4300, "R12 byte enable", c, 16'h4300);
    wr(6'd32, 16'h0001); rd(6'd32, s);
    check(s == 16'h0002, "R5 write to busy bit ignored", s, 16'h0002);
  endtask

  task automatic t_smi();
    logic [15:0] s;
    wr(6'd32, 16'h0002); rd(6'd32, s);
    check(s == 16'h0000, "R6 done cleared by one", s, 16'h0000);
    wr(6'd33, 16'hC003);
    #1 check(smi_req == 1'b0, "R7 smi low while busy", smi_req, 0);
    wait_idle(); #1;
    check(smi_req == 1'b1, "R7 smi on done", smi_req, 1);
    wr(6'd32, 16'h0002); #1;
    check(smi_req == 1'b0, "R7 smi drops", smi_req, 0);
  endtask

  task automatic t_nodata();
    int f0;
    f0 = frames;
    wr(6'd33, 16'h0503);
    wait_idle();
    check(frames == f0 + 1 && capn == 4 && bitn == 0, "R3 no data phase", capn, 4);
  endtask

  task automatic t_write();
    int bad;
    logic [15:0] w;
    for (int i = 0; i < 32; i++) wr(6'(i), {pat(2 * i + 1), pat(2 * i)});
    wr(6'd34, 16'hABCD); wr(6'd35, 16'h0000);
    wr(6'd33, 16'h7F02);
    wait_idle();
    check(capn == 68, "R3 64 byte phase", capn, 68);
    bad = 0;
    for (int i = 0; i < 64; i++) if (cap[4 + i] != pat(i)) bad++;
    check(bad == 0, "R4 buffer order out", bad, 0);
    rd(6'd0, w);
    check(w == {pat(1), pat(0)}, "R4 buffer kept on send", w, {pat(1), pat(0)});
  endtask

  task automatic t_busy();
    logic [15:0] s, a, w;
    int f0;
    f0 = frames;
    wr(6'd32, 16'h0002);
    wr(6'd33, 16'h4003);
    wr(6'd34, 16'hFFFF);
    wr(6'd20, 16'h0000);
    wr(6'd33, 16'h4003);
    rd(6'd32, s);
    check(s == 16'h0005, "R8 blocked while busy", s, 16'h0005);
    wait_idle();
    rd(6'd34, a); rd(6'd20, w);
    check(a == 16'hABCD, "R8 address kept", a, 16'hABCD);
    check(w == {pat(41), pat(40)}, "R8 buffer kept", w, {pat(41), pat(40)});
    check(frames == f0 + 1, "R8 one frame only", frames, f0 + 1);
    wr(6'd32, 16'h0000); rd(6'd32, s);
    check(s == 16'h0006, "R9 blocked sticky", s, 16'h0006);
    wr(6'd32, 16'h0004); rd(6'd32, s);
    check(s == 16'h0002, "R9 blocked cleared", s, 16'h0002);
  endtask

  task automatic t_protect();
    logic [15:0] s, b;
    int f0;
    wr(6'd36, 16'h1000); wr(6'd37, 16'h0000); wr(6'd38, 16'h1FFF); wr(6'd39, 16'h0000);
    wr(6'd32, 16'h8000, 2'b10);
    wr(6'd36, 16'h5555); rd(6'd36, b);
    check(b == 16'h1000, "R10 base frozen", b, 16'h1000);
    wr(6'd32, 16'h0002); rd(6'd32, s);
    check(s == 16'h8000, "R10 lock sticky", s, 16'h8000);
    wr(6'd34, 16'h1800);
    f0 = frames;
    wr(6'd33, 16'h0002); rd(6'd32, s);
    check(s == 16'h8004, "R11 program refused", s, 16'h8004);
    wr(6'd33, 16'h0052);
    repeat (40) @(negedge clk);
    rd(6'd32, s);
    check(frames == f0 && s == 16'h8004, "R11 erase refused no frame", {16'(frames - f0), s}, {16'd0, 16'h8004});
    wr(6'd32, 16'h0004);
    wr(6'd33, 16'h0003); wait_idle(); rd(6'd32, s);
    check(frames == f0 + 1 && s == 16'h8002, "R11 read in range allowed", s, 16'h8002);
    wr(6'd32, 16'h0002);
    wr(6'd34, 16'h2000);
    wr(6'd33, 16'h0002); wait_idle(); rd(6'd32, s);
    check(frames == f0 + 2 && s == 16'h8002, "R11 program outside range", s, 16'h8002);
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; failed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read();
    t_smi();
    t_nodata();
    t_write();
    t_busy();
    t_protect();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule